// File: doc/BRIEF.md
# Multi-format video sample demultiplexer

This block sits between a video pixel source and a three-channel converter. It takes component samples on up to three 10-bit ports and steers them into three channels: Y (or G), Pb (or B) and Pr (or R). A two-bit format select chooses the format. The choices are full-rate 4:4:4 in either GBR or YPbPr colour, 4:2:2 with luma on one port and interleaved chroma on a second port, or 4:2:2 with luma and both chroma components interleaved on a single port. Each channel output is a registered word with an update strobe. The strobe is high in every cycle in which that word was rewritten, and the word holds its value in all other cycles.

The active-low blanking input frames each line. While blanking is asserted, the block drives a fixed blanking code on every channel, and it accepts a new format from the select pins. On the first valid sample after blanking is released, the chroma sequencing restarts from a known phase. The chroma blanking code is either zero or mid-scale. It depends on the format and on two settings: whether sync is inserted on all channels, and a variant select that keeps chroma at mid-scale even when sync is carried on luma only.

On the input side, `in_valid` marks a sample. There is no ready signal, because the block accepts a sample in every cycle and never applies back-pressure. A cycle with `in_valid` low is a bubble: no output updates in that cycle and the phase of the sequence does not advance. The output strobes have no back-pressure either, so the converter must consume every strobed word.

Top module: `vid_demux`

## Requirements
- R1: While `rst_n` is low, all three outputs are 0 and all three strobes are 0.
- R2: With active format 00 (GBR) or 01 (YPbPr 4:4:4), each valid unblanked sample is handled the same way. On the next clock, `y_out`, `pb_out` and `pr_out` equal `y_in`, `pb_in` and `pr_in`, and all three strobes are 1.
- R3: After a clock edge at which `blank_n` is low, `y_out` is 0 and all three strobes are 1.
- R4: After a clock edge at which `blank_n` is low, `pb_out` and `pr_out` equal the chroma blanking code. The code is 512 when `fmt_sel` is 01, 10 or 11 and at least one of `sync_all` and `keep_mid` is 1. In every other case the code is 0, and format 00 always gives 0.
- R5: In format 10, every valid sample updates `y_out` from `y_in` with `y_stb`. The `pr_in` port carries chroma in the order Pb, Pr, and the first valid sample after blanking is released is Pb. After the Pr sample of a pair has been captured, `pb_out` and `pr_out` update together, with both strobes high in the same cycle.
- R6: In format 11, only `y_in` carries data. Valid samples repeat the order Pb, Y, Pr, Y, and the first valid sample after release is Pb. Each Y sample updates `y_out` with `y_stb`. Each Pr sample updates `pb_out` and `pr_out` together with both strobes. A Pb sample produces no strobe.
- R7: A strobe that is low means its output kept its previous value. A cycle with `in_valid` low and `blank_n` high leaves every strobe low and does not advance the sequence.
- R8: The active format is taken from `fmt_sel` only at clock edges where `blank_n` is low. Changing `fmt_sel` while unblanked has no effect on the steering.
- R9: Releasing blanking always restarts chroma at Pb. A Pb sample that was captured before a blanking interval is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Format select: 00 GBR 4:4:4, 01 YPbPr 4:4:4, 10 4:2:2 two-port, 11 4:2:2 one-port |
| sync_all | input | 1 | 1 when sync is inserted on all three channels |
| keep_mid | input | 1 | 1 keeps chroma blanking at mid-scale even when sync is on luma only |
| blank_n | input | 1 | Active-low blanking |
| in_valid | input | 1 | Input sample valid (no ready; always accepted) |
| y_in | input | 10 | Y/G port, or the multiplexed port in format 11 |
| pb_in | input | 10 | Pb/B port |
| pr_in | input | 10 | Pr/R port, or the interleaved chroma port in format 10 |
| y_out | output | 10 | Y/G channel word |
| pb_out | output | 10 | Pb/B channel word |
| pr_out | output | 10 | Pr/R channel word |
| y_stb | output | 1 | `y_out` updated this cycle |
| pb_stb | output | 1 | `pb_out` updated this cycle |
| pr_stb | output | 1 | `pr_out` updated this cycle |

## Verification
A phase counter that has slipped shows up within one chroma pair. In the two-port format, a wrong phase puts a Pr sample on `pb_out` or makes the chroma strobes fire on the wrong sample. In the one-port format, luma lands on a chroma output, or `y_stb` fires on a chroma slot, within four samples. A wrongly latched format corrupts the very first valid sample after release. A stale held Pb sample is visible as a wrong `pb_out` at the first pair after a blanking interval.

// File: rtl/vdm_pkg.sv
package vdm_pkg;
  typedef enum logic [1:0] {
    FMT_GBR    = 2'b00,
    FMT_YC444  = 2'b01,
    FMT_YC2P   = 2'b10,
    FMT_YC1P   = 2'b11
  } fmt_e;
endpackage

// File: rtl/vdm_fmt_latch.sv
module vdm_fmt_latch
  import vdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blank_n,
  input  logic [1:0] fmt_sel,
  output fmt_e       act_fmt
);
  // the format is only accepted between lines
  always_ff @(posedge clk) begin
    if (!rst_n)        act_fmt <= FMT_GBR;
    else if (!blank_n) act_fmt <= fmt_e'(fmt_sel);
  end
endmodule

// File: rtl/vdm_phase.sv
module vdm_phase #(
  parameter int unsigned PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank_n,
  input  logic          in_valid,
  output logic [PW-1:0] ph
);
  always_ff @(posedge clk) begin
    if (!rst_n || !blank_n) ph <= '0;
    else if (in_valid)      ph <= ph + 1'b1;
  end
endmodule

// File: rtl/vdm_steer.sv
module vdm_steer
  import vdm_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         act_fmt,
  input  logic [1:0]   fmt_sel,
  input  logic         sync_all,
  input  logic         keep_mid,
  input  logic         blank_n,
  input  logic         in_valid,
  input  logic [1:0]   ph,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pr_in,
  output logic [W-1:0] y_out,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pr_out,
  output logic         y_stb,
  output logic         pb_stb,
  output logic         pr_stb
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0] c_blank;
  logic [W-1:0] cb_hold;

  // chroma blanking level follows the format being latched
  always_comb begin
    if ((fmt_sel != FMT_GBR) && (sync_all || keep_mid)) c_blank = MID;
    else                                                c_blank = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out   <= '0;
      pb_out  <= '0;
      pr_out  <= '0;
      y_stb   <= 1'b0;
      pb_stb  <= 1'b0;
      pr_stb  <= 1'b0;
      cb_hold <= '0;
    end else begin
      y_stb  <= 1'b0;
      pb_stb <= 1'b0;
      pr_stb <= 1'b0;
      if (!blank_n) begin
        y_out  <= '0;
        pb_out <= c_blank;
        pr_out <= c_blank;
        y_stb  <= 1'b1;
        pb_stb <= 1'b1;
        pr_stb <= 1'b1;
      end else if (in_valid) begin
        unique case (act_fmt)
          FMT_GBR, FMT_YC444: begin
            y_out  <= y_in;
            pb_out <= pb_in;
            pr_out <= pr_in;
            y_stb  <= 1'b1;
            pb_stb <= 1'b1;
            pr_stb <= 1'b1;
          end
          FMT_YC2P: begin
            y_out <= y_in;
            y_stb <= 1'b1;
            if (!ph[0]) begin
              cb_hold <= pr_in;
            end else begin
              pb_out <= cb_hold;
              pr_out <= pr_in;
              pb_stb <= 1'b1;
              pr_stb <= 1'b1;
            end
          end
          FMT_YC1P: begin
            unique case (ph)
              2'd0: cb_hold <= y_in;
              2'd2: begin
                pb_out <= cb_hold;
                pr_out <= y_in;
                pb_stb <= 1'b1;
                pr_stb <= 1'b1;
              end
              default: begin
                y_out <= y_in;
                y_stb <= 1'b1;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vid_demux.sv
module vid_demux
  import vdm_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   fmt_sel,
  input  logic         sync_all,
  input  logic         keep_mid,
  input  logic         blank_n,
  input  logic         in_valid,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pr_in,
  output logic [W-1:0] y_out,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pr_out,
  output logic         y_stb,
  output logic         pb_stb,
  output logic         pr_stb
);
  localparam int unsigned PW = 2;

  fmt_e          act_fmt;
  logic [PW-1:0] ph;

  vdm_fmt_latch u_fmt (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n),
    .fmt_sel(fmt_sel), .act_fmt(act_fmt)
  );

  vdm_phase #(.PW(PW)) u_ph (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n),
    .in_valid(in_valid), .ph(ph)
  );

  vdm_steer #(.W(W)) u_steer (
    .clk(clk), .rst_n(rst_n), .act_fmt(act_fmt), .fmt_sel(fmt_sel),
    .sync_all(sync_all), .keep_mid(keep_mid), .blank_n(blank_n),
    .in_valid(in_valid), .ph(ph),
    .y_in(y_in), .pb_in(pb_in), .pr_in(pr_in),
    .y_out(y_out), .pb_out(pb_out), .pr_out(pr_out),
    .y_stb(y_stb), .pb_stb(pb_stb), .pr_stb(pr_stb)
  );
endmodule

// File: rtl/vid_demux_chk.sv
module vid_demux_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         blank_n,
  input logic         in_valid,
  input logic [1:0]   act_fmt,
  input logic [W-1:0] y_out,
  input logic [W-1:0] pb_out,
  input logic         y_stb,
  input logic         pb_stb,
  input logic         pr_stb
);
  // R3
  blank_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (y_out == '0) && y_stb && pb_stb && pr_stb);

  // R8
  fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_n |=> act_fmt == $past(act_fmt));

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_n && in_valid && !act_fmt[1] |=> y_stb && pb_stb && pr_stb);

  // R5
  pair_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_stb |-> pr_stb);

  // R7
  hold_pb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_stb |-> $stable(pb_out));

  // R7
  hold_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !y_stb |-> $stable(y_out));
endmodule

bind vid_demux vid_demux_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .in_valid(in_valid),
  .act_fmt(act_fmt), .y_out(y_out), .pb_out(pb_out),
  .y_stb(y_stb), .pb_stb(pb_stb), .pr_stb(pr_stb)
);

// File: tb/vid_demux_test.sv
`timescale 1ns/1ps
module vid_demux_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] fmt_sel;
  logic       sync_all, keep_mid, blank_n, in_valid;
  logic [9:0] y_in, pb_in, pr_in;
  logic [9:0] y_out, pb_out, pr_out;
  logic       y_stb, pb_stb, pr_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vid_demux uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sync_all(sync_all),
    .keep_mid(keep_mid), .blank_n(blank_n), .in_valid(in_valid),
    .y_in(y_in), .pb_in(pb_in), .pr_in(pr_in),
    .y_out(y_out), .pb_out(pb_out), .pr_out(pr_out),
    .y_stb(y_stb), .pb_stb(pb_stb), .pr_stb(pr_stb)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic stbs(input string tag, input logic ey, input logic eb, input logic er);
    chk({tag, " y_stb"}, {9'd0, y_stb}, {9'd0, ey});
    chk({tag, " pb_stb"}, {9'd0, pb_stb}, {9'd0, eb});
    chk({tag, " pr_stb"}, {9'd0, pr_stb}, {9'd0, er});
  endtask

  task automatic enter(input logic [1:0] f);
    fmt_sel = f; blank_n = 1'b0; in_valid = 1'b0;
    cyc(); cyc();
    blank_n = 1'b1;
  endtask

  task automatic smp(input logic [9:0] y, input logic [9:0] b, input logic [9:0] r);
    y_in = y; pb_in = b; pr_in = r; in_valid = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fmt_sel = 2'b00; sync_all = 1'b0; keep_mid = 1'b0;
    blank_n = 1'b0; in_valid = 1'b0; y_in = '0; pb_in = '0; pr_in = '0;
    repeat (3) cyc();
    chk("R1 y_out", y_out, 10'd0);
    chk("R1 pb_out", pb_out, 10'd0);
    chk("R1 pr_out", pr_out, 10'd0);
    stbs("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_full(input logic [1:0] f);
    enter(f);
    for (int i = 0; i < 4; i++) begin
      smp(10'(30 + i), 10'(500 + i), 10'(900 + i));
      chk("R2 y_out", y_out, 10'(30 + i));
      chk("R2 pb_out", pb_out, 10'(500 + i));
      chk("R2 pr_out", pr_out, 10'(900 + i));
      stbs("R2", 1'b1, 1'b1, 1'b1);
    end
  endtask

  task automatic t_blank();
    fmt_sel = 2'b01; sync_all = 1'b1; keep_mid = 1'b0; blank_n = 1'b0; in_valid = 1'b1;
    cyc(); cyc();
    chk("R3 y_out", y_out, 10'd0);
    stbs("R3", 1'b1, 1'b1, 1'b1);
    chk("R4 pb sync_all", pb_out, 10'd512);
    chk("R4 pr sync_all", pr_out, 10'd512);
    sync_all = 1'b0;
    cyc();
    chk("R4 pb luma-only", pb_out, 10'd0);
    keep_mid = 1'b1;
    cyc();
    chk("R4 pr keep_mid", pr_out, 10'd512);
    fmt_sel = 2'b00; sync_all = 1'b1;
    cyc();
    chk("R4 pb gbr", pb_out, 10'd0);
    fmt_sel = 2'b11;
    cyc();
    chk("R4 pb one-port", pb_out, 10'd512);
    sync_all = 1'b0; keep_mid = 1'b0;
  endtask

  task automatic t_two();
    enter(2'b10);
    smp(10'd11, 10'd0, 10'd101);
    chk("R5 y first", y_out, 10'd11);
    stbs("R5 Pb slot", 1'b1, 1'b0, 1'b0);
    smp(10'd12, 10'd0, 10'd102);
    chk("R5 y second", y_out, 10'd12);
    chk("R5 pb", pb_out, 10'd101);
    chk("R5 pr", pr_out, 10'd102);
    stbs("R5 Pr slot", 1'b1, 1'b1, 1'b1);
    smp(10'd13, 10'd0, 10'd103);
    in_valid = 1'b0; y_in = 10'd777; pr_in = 10'd778;
    cyc();
    stbs("R7 bubble", 1'b0, 1'b0, 1'b0);
    chk("R7 y held", y_out, 10'd13);
    chk("R7 pb held", pb_out, 10'd101);
    smp(10'd14, 10'd0, 10'd104);
    chk("R7 pb after bubble", pb_out, 10'd103);
    chk("R7 pr after bubble", pr_out, 10'd104);
  endtask

  task automatic t_one(input int n, input logic [9:0] base);
    for (int k = 0; k < n; k++) begin
      smp(base + 10'(k * 4), 0, 0);
      stbs("R6 Pb slot", 1'b0, 1'b0, 1'b0);
      smp(base + 10'(k * 4 + 1), 0, 0);
      chk("R6 y1", y_out, base + 10'(k * 4 + 1));
      stbs("R6 Y slot", 1'b1, 1'b0, 1'b0);
      smp(base + 10'(k * 4 + 2), 0, 0);
      chk("R6 pb", pb_out, base + 10'(k * 4));
      chk("R6 pr", pr_out, base + 10'(k * 4 + 2));
      stbs("R6 Pr slot", 1'b0, 1'b1, 1'b1);
      smp(base + 10'(k * 4 + 3), 0, 0);
      chk("R6 y3", y_out, base + 10'(k * 4 + 3));
    end
  endtask

  task automatic t_fmt_change();
    enter(2'b11);
    fmt_sel = 2'b00;
    t_one(1, 10'd200);
    chk("R8 pb one-port kept", pb_out, 10'd200);
  endtask

  task automatic t_rephase();
    enter(2'b10);
    smp(10'd1, 10'd0, 10'd55);
    blank_n = 1'b0; in_valid = 1'b0;
    cyc();
    blank_n = 1'b1;
    smp(10'd2, 10'd0, 10'd66);
    stbs("R9 first is Pb", 1'b1, 1'b0, 1'b0);
    smp(10'd3, 10'd0, 10'd77);
    chk("R9 pb", pb_out, 10'd66);
    chk("R9 pr", pr_out, 10'd77);
  endtask

  initial begin
    t_reset();
    t_full(2'b00);
    t_full(2'b01);
    t_blank();
    t_two();
    enter(2'b11);
    t_one(2, 10'd300);
    t_fmt_change();
    t_rephase();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule